// File: doc/BRIEF.md
# Single-Shot Delta-Sigma ADC Conversion Sequencer

This block drives the serial side of a slow, high-resolution delta-sigma converter that works one conversion at a time. When it gets a start request, it pulls chip select low for a short fixed interval to start a conversion. It then releases chip select and leaves the serial clock parked for the whole conversion time, so the bus stays quiet. After that wait it selects the converter again and clocks in the result, most significant bit first.

The result field is 24 bits wide. When the serial clock idles low, the converter sends one extra readiness bit ahead of the data, and the sequencer drops it. The captured value is sign-extended to the output width. Two flags report when the value lies beyond the 21-bit full scale of ±2^20. The result is held on a valid/ready handshake until it is taken.

The converter powers down its analog section if it sits idle long enough after a read. The sequencer counts the idle time since the last fetch. When that time crosses a threshold, it lengthens the next wait by a power-up allowance of a fixed number of serial-clock periods. All durations are parameters counted in system clock cycles. The serial clock is a divided copy of the system clock.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset the block is quiet: `cs_n_o` is 1, `sclk_o` equals `cpol_i`, and `busy_o` and `res_valid_o` are both 0.
- R2: A start request accepted while idle drives `cs_n_o` low for exactly START_CYC cycles. During that interval `sclk_o` stays at the idle level `cpol_i` and makes no transitions.
- R3: After the start pulse, `cs_n_o` stays high for exactly CONV_CYC cycles before the fetch, and `sclk_o` stays at `cpol_i` whenever `cs_n_o` is high.
- R4: The converter counts as powered down after reset, and also when at least SHDN_CYC cycles have passed between the end of the previous fetch and the next start request. In that case the wait of R3 grows by PWRUP_SCK × 2 × SCK_HALF cycles.
- R5: During the fetch, `sclk_o` makes 24 pulses when `cpol_i` is 1 and 25 pulses when `cpol_i` is 0. Each pulse leaves the idle level for SCK_HALF cycles. `miso_i` is sampled as the pulse returns to the idle level, first bit most significant. With 25 pulses the first sampled bit is dropped.
- R6: `res_data_o` holds the 24-bit two's-complement field sign-extended to OUT_W bits.
- R7: `res_ovr_o` is 1 exactly when the signed field exceeds 1048575. `res_unr_o` is 1 exactly when it is below −1048576. At most one of them is 1.
- R8: `res_valid_o` rises in the cycle that `cs_n_o` rises at the end of the fetch. While `res_ready_i` is 0 it stays high with data and flags unchanged.
- R9: `busy_o` rises the cycle after an accepted start request and falls the cycle after `res_valid_o` and `res_ready_i` are both 1.
- R10: A start request while `busy_o` is 1 has no effect: the running conversion keeps its timing, and after the handshake the block stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request one conversion |
| cpol_i | input | 1 | Static idle level of the serial clock |
| miso_i | input | 1 | Serial data from the converter |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock |
| busy_o | output | 1 | Conversion in progress or result not yet taken |
| res_valid_o | output | 1 | Result available |
| res_ready_i | input | 1 | Result accepted |
| res_data_o | output | OUT_W | Sign-extended result |
| res_ovr_o | output | 1 | Result above positive full scale |
| res_unr_o | output | 1 | Result below negative full scale |

## Verification
Two functions can act in the same cycle: the idle-time counter that decides power-down, and the start request that reads its verdict and clears it. The bench places start requests either shortly after a result hand-off or well past the shutdown threshold, at random, and uses the measured chip-select-high interval to judge whether the power-up allowance was applied. A start request is also injected in the middle of the released wait. This checks that the long idle phase, where chip select is high and the bus looks free, is not mistaken for idle.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_WAIT  = 3'd2,
    S_FETCH = 3'd3,
    S_HOLD  = 3'd4
  } seq_state_e;

endpackage

// File: rtl/adc_seq_timer.sv
// Loadable down counter; zero_o flags the last cycle of an interval.
module adc_seq_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_sclk.sv
// Serial clock generator: idle half then active half per bit, sample at return to idle.
module adc_seq_sclk #(
  parameter int HALF = 2,
  parameter int BW   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          cpol_i,
  input  logic [BW-1:0] nbits_i,
  output logic          sclk_o,
  output logic          sample_o,
  output logic          last_o
);

  localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] hcnt_q, hcnt_d;
  logic          phase_q, phase_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          half_end;

  assign half_end = (hcnt_q == HW'(HALF - 1));
  assign sample_o = en_i && phase_q && half_end;
  assign last_o   = sample_o && (bit_q == nbits_i - 1'b1);

  always_comb begin
    hcnt_d  = hcnt_q;
    phase_d = phase_q;
    bit_d   = bit_q;
    if (!en_i) begin
      hcnt_d  = '0;
      phase_d = 1'b0;
      bit_d   = '0;
    end else if (half_end) begin
      hcnt_d  = '0;
      phase_d = !phase_q;
      if (phase_q) begin
        bit_d = bit_q + 1'b1;
      end
    end else begin
      hcnt_d = hcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q  <= '0;
      phase_q <= 1'b0;
      bit_q   <= '0;
    end else begin
      hcnt_q  <= hcnt_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
    end
  end

  assign sclk_o = (en_i && phase_q) ? !cpol_i : cpol_i;

endmodule

// File: rtl/adc_seq_shift.sv
// Input shifter, sign extension and full-scale range flags.
module adc_seq_shift #(
  parameter int DW = 24,
  parameter int OW = 32,
  parameter int FS = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_i,
  input  logic          capture_i,
  input  logic          miso_i,
  output logic [OW-1:0] data_o,
  output logic          ovr_o,
  output logic          unr_o
);

  logic [DW-1:0] sh_q;
  logic [DW-1:0] word;
  logic [OW-1:0] data_d;
  logic          ovr_d, unr_d;

  assign word = {sh_q[DW-2:0], miso_i};

  always_comb begin
    data_d = {{(OW-DW){word[DW-1]}}, word};
    ovr_d  = !word[DW-1] && (word[DW-2:FS] != '0);
    unr_d  =  word[DW-1] && (word[DW-2:FS] != '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (sample_i) begin
      sh_q <= word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o <= '0;
      ovr_o  <= 1'b0;
      unr_o  <= 1'b0;
    end else if (capture_i) begin
      data_o <= data_d;
      ovr_o  <= ovr_d;
      unr_o  <= unr_d;
    end
  end

endmodule

// File: rtl/adc_seq_sleep.sv
// Idle-time tracker deciding whether the converter has powered down.
module adc_seq_sleep #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_i,
  input  logic clr_i,
  output logic asleep_o
);

  localparam int SW = $clog2(LIMIT + 1);

  logic [SW-1:0] cnt_q, cnt_d;
  logic          asleep_d;
  logic          upd;

  assign upd = clr_i || (count_i && !asleep_o);

  always_comb begin
    cnt_d    = cnt_q;
    asleep_d = asleep_o;
    if (clr_i) begin
      cnt_d    = '0;
      asleep_d = 1'b0;
    end else if (count_i) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_d >= SW'(LIMIT)) begin
        asleep_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      asleep_o <= 1'b1;
    end else if (upd) begin
      cnt_q    <= cnt_d;
      asleep_o <= asleep_d;
    end
  end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int START_CYC = 400,
  parameter int CONV_CYC  = 4000000,
  parameter int SHDN_CYC  = 500,
  parameter int SCK_HALF  = 10,
  parameter int PWRUP_SCK = 144,
  parameter int DATA_W    = 24,
  parameter int FS_BITS   = 20,
  parameter int OUT_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             cpol_i,
  input  logic             miso_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [OUT_W-1:0] res_data_o,
  output logic             res_ovr_o,
  output logic             res_unr_o
);

  localparam int PWRUP_CYC = PWRUP_SCK * 2 * SCK_HALF;
  localparam int TW        = $clog2(CONV_CYC + PWRUP_CYC + START_CYC + 1);
  localparam int BW        = $clog2(DATA_W + 2);

  logic [1:0]    rsync_q;
  logic          rst_ns;
  seq_state_e    st_q, st_d;
  logic          pwr_q, pwr_d;
  logic          t_load, t_zero;
  logic [TW-1:0] t_val;
  logic          sl_clr, asleep;
  logic          fetch_en, sample, last;
  logic [BW-1:0] nbits;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_ns = rsync_q[1];

  assign nbits = cpol_i ? BW'(DATA_W) : BW'(DATA_W + 1);

  always_comb begin
    st_d   = st_q;
    pwr_d  = pwr_q;
    t_load = 1'b0;
    t_val  = TW'(START_CYC - 1);
    sl_clr = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (start_i) begin
          st_d   = S_START;
          t_load = 1'b1;
          sl_clr = 1'b1;
          pwr_d  = asleep;
        end
      end
      S_START: begin
        if (t_zero) begin
          st_d   = S_WAIT;
          t_load = 1'b1;
          t_val  = TW'(CONV_CYC - 1) + (pwr_q ? TW'(PWRUP_CYC) : '0);
        end
      end
      S_WAIT: begin
        if (t_zero) begin
          st_d = S_FETCH;
        end
      end
      S_FETCH: begin
        if (last) begin
          st_d = S_HOLD;
        end
      end
      S_HOLD: begin
        if (res_ready_i) begin
          st_d = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q  <= S_IDLE;
      pwr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pwr_q <= pwr_d;
    end
  end

  assign fetch_en    = (st_q == S_FETCH);
  assign cs_n_o      = !((st_q == S_START) || fetch_en);
  assign busy_o      = (st_q != S_IDLE);
  assign res_valid_o = (st_q == S_HOLD);

  adc_seq_timer #(.TW(TW)) timer_i (
    .clk        (clk),
    .rst_n      (rst_ns),
    .load_i     (t_load),
    .load_val_i (t_val),
    .zero_o     (t_zero)
  );

  adc_seq_sleep #(.LIMIT(SHDN_CYC)) sleep_i (
    .clk      (clk),
    .rst_n    (rst_ns),
    .count_i  ((st_q == S_HOLD) || (st_q == S_IDLE)),
    .clr_i    (sl_clr),
    .asleep_o (asleep)
  );

  adc_seq_sclk #(.HALF(SCK_HALF), .BW(BW)) sclk_i (
    .clk      (clk),
    .rst_n    (rst_ns),
    .en_i     (fetch_en),
    .cpol_i   (cpol_i),
    .nbits_i  (nbits),
    .sclk_o   (sclk_o),
    .sample_o (sample),
    .last_o   (last)
  );

  adc_seq_shift #(.DW(DATA_W), .OW(OUT_W), .FS(FS_BITS)) shift_i (
    .clk       (clk),
    .rst_n     (rst_ns),
    .sample_i  (sample),
    .capture_i (last),
    .miso_i    (miso_i),
    .data_o    (res_data_o),
    .ovr_o     (res_ovr_o),
    .unr_o     (res_unr_o)
  );

endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk #(
  parameter int OW = 32,
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          cpol_i,
  input logic          cs_n_o,
  input logic          sclk_o,
  input logic          busy_o,
  input logic          res_valid_o,
  input logic          res_ready_i,
  input logic [OW-1:0] res_data_o,
  input logic          res_ovr_o,
  input logic          res_unr_o
);

  AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n) cs_n_o |-> (sclk_o == cpol_i)); // R3
  AST_START_SELECT: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> (busy_o && !cs_n_o && (sclk_o == cpol_i))); // R2
  AST_VALID_HELD: assert property (@(posedge clk) disable iff (!rst_n) (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o) && $stable(res_ovr_o) && $stable(res_unr_o))); // R8
  AST_VALID_DESELECT: assert property (@(posedge clk) disable iff (!rst_n) res_valid_o |-> (cs_n_o && busy_o)); // R8
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> $past(res_valid_o && res_ready_i)); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n) res_valid_o |-> !(res_ovr_o && res_unr_o)); // R7
  AST_OVR_SIGN: assert property (@(posedge clk) disable iff (!rst_n) (res_valid_o && res_ovr_o) |-> !res_data_o[OW-1]); // R7
  AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n) res_valid_o |-> ((res_data_o[OW-1:DW-1] == '0) || (res_data_o[OW-1:DW-1] == '1))); // R6

endmodule

bind adc_conv_seq adc_conv_seq_chk #(.OW(OUT_W), .DW(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_ns),
  .start_i     (start_i),
  .cpol_i      (cpol_i),
  .cs_n_o      (cs_n_o),
  .sclk_o      (sclk_o),
  .busy_o      (busy_o),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_data_o  (res_data_o),
  .res_ovr_o   (res_ovr_o),
  .res_unr_o   (res_unr_o)
);

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int P_START    = 6;
  localparam int P_CONV     = 50;
  localparam int P_SHDN     = 40;
  localparam int P_HALF     = 2;
  localparam int P_PWR_SCK  = 144;
  localparam int P_PWR_CYC  = P_PWR_SCK * 2 * P_HALF;
  localparam int WDOG       = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        cpol_i = 1'b1;
  logic        miso_i = 1'b0;
  logic        res_ready_i = 1'b0;
  logic        cs_n_o, sclk_o, busy_o, res_valid_o, res_ovr_o, res_unr_o;
  logic [31:0] res_data_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int fetch_end = 0;
  bit first = 1'b1;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = !clk;
  always @(posedge clk) cyc <= cyc + 1;

  adc_conv_seq #(
    .START_CYC (P_START),
    .CONV_CYC  (P_CONV),
    .SHDN_CYC  (P_SHDN),
    .SCK_HALF  (P_HALF),
    .PWRUP_SCK (P_PWR_SCK),
    .DATA_W    (24),
    .FS_BITS   (20),
    .OUT_W     (32)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .cpol_i      (cpol_i),
    .miso_i      (miso_i),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .busy_o      (busy_o),
    .res_valid_o (res_valid_o),
    .res_ready_i (res_ready_i),
    .res_data_o  (res_data_o),
    .res_ovr_o   (res_ovr_o),
    .res_unr_o   (res_unr_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data(input logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction

  function automatic bit exp_ovr(input logic [23:0] v);
    return $signed(exp_data(v)) > 32'sd1048575;
  endfunction

  function automatic bit exp_unr(input logic [23:0] v);
    return $signed(exp_data(v)) < -32'sd1048576;
  endfunction

  task automatic conv(input logic [23:0] v, input bit cp, input int idle_gap, input bit poke);
    int n;
    int m;
    int nb;
    int pulses;
    int hold;
    int gap;
    bit sleep_exp;
    bit prev;
    bit sclk_bad;
    logic [24:0] frame;
    logic [31:0] snap;

    cpol_i = cp;
    repeat (idle_gap) @(negedge clk);
    gap = cyc - fetch_end;
    sleep_exp = first || (gap >= P_SHDN);

    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R9", "busy after start", busy_o, 1);

    // R2: start pulse length, clock parked
    n = 0;
    sclk_bad = 1'b0;
    while (!cs_n_o) begin
      if (sclk_o != cp) sclk_bad = 1'b1;
      n++;
      @(negedge clk);
    end
    chk(n == P_START, "R2", "start pulse cycles", n, P_START);
    chk(!sclk_bad, "R2", "sclk moved in start pulse", sclk_bad, 0);

    // R3/R4: released wait, optional ignored start (R10)
    m = 0;
    sclk_bad = 1'b0;
    while (cs_n_o) begin
      start_i = (poke && m == 3);
      if (sclk_o != cp) sclk_bad = 1'b1;
      m++;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (sleep_exp)
      chk(m == P_CONV + P_PWR_CYC, "R4", "wait with power-up", m, P_CONV + P_PWR_CYC);
    else
      chk(m == P_CONV, "R3", "wait awake", m, P_CONV);
    chk(!sclk_bad, "R3", "sclk moved in wait", sclk_bad, 0);

    // R5: fetch, bench acts as converter
    nb = cp ? 24 : 25;
    frame = {1'b1, v};
    pulses = 0;
    prev = cp;
    while (!cs_n_o) begin
      if (sclk_o != prev && sclk_o != cp) begin
        miso_i = frame[nb - 1 - pulses];
        pulses++;
      end
      prev = sclk_o;
      @(negedge clk);
    end
    fetch_end = cyc;
    chk(pulses == nb, "R5", "clock pulses", pulses, nb);
    chk(res_valid_o == 1'b1, "R8", "valid at deselect", res_valid_o, 1);
    chk(res_data_o == exp_data(v), "R6", "data", res_data_o, exp_data(v));
    chk(res_ovr_o == exp_ovr(v), "R7", "over flag", res_ovr_o, exp_ovr(v));
    chk(res_unr_o == exp_unr(v), "R7", "under flag", res_unr_o, exp_unr(v));

    hold = $urandom % 4;
    snap = res_data_o;
    repeat (hold) begin
      @(negedge clk);
      chk(res_valid_o && res_data_o == snap, "R8", "held result", res_data_o, snap);
    end
    res_ready_i = 1'b1;
    @(negedge clk);
    res_ready_i = 1'b0;
    chk(res_valid_o == 1'b0, "R9", "valid after accept", res_valid_o, 0);
    chk(busy_o == 1'b0, "R9", "busy after accept", busy_o, 0);

    if (poke) begin
      repeat (4) begin
        @(negedge clk);
        chk(!busy_o && cs_n_o, "R10", "no restart from ignored start", busy_o, 0);
      end
    end
    first = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20171009));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(cs_n_o == 1'b1, "R1", "cs after reset", cs_n_o, 1);
    chk(sclk_o == cpol_i, "R1", "sclk after reset", sclk_o, cpol_i);
    chk(busy_o == 1'b0 && res_valid_o == 1'b0, "R1", "busy/valid after reset",
        {busy_o, res_valid_o}, 0);

    // directed corners around full scale, both clock polarities
    conv(24'h0FFFFF, 1'b1, 0, 1'b0);
    conv(24'h100000, 1'b0, 2, 1'b0);
    conv(24'hF00000, 1'b1, 70, 1'b0);
    conv(24'hEFFFFF, 1'b0, 1, 1'b1);
    conv(24'h7FFFFF, 1'b1, 3, 1'b0);
    conv(24'h800000, 1'b0, 80, 1'b1);
    conv(24'h000000, 1'b0, 0, 1'b0);
    conv(24'hFFFFFF, 1'b1, 65, 1'b0);

    // random mix
    for (int i = 0; i < 18; i++) begin
      logic [23:0] v;
      int g;
      v = 24'($urandom);
      if ($urandom % 2) v = {{3{v[20]}}, v[20:0]};
      g = ($urandom % 2) ? int'($urandom % 6) : 60 + int'($urandom % 30);
      conv(v, 1'($urandom), g, 1'($urandom % 4 == 0));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cyc >= WDOG);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule